// File: doc/BRIEF.md
# Multi-line receive silo with alarm

This block gathers characters from eight serial receivers into one shared first-in first-out silo. Each receiver has a valid strobe, an 8-bit character and a break flag. Software sees the silo through a small two-word register port. Word 0 is the control and status word. Reading word 1 pops the oldest entry, which carries the character, its line number and the break and valid flags. Writing word 1 switches one line's receiver on or off.

A receive-done flag shows that the scanner is running and the silo holds data. A silo-alarm flag fires once when the fill reaches a fixed level. After that it stays disarmed until software reads the silo empty. A single interrupt request follows either the alarm or the done flag, chosen by an alarm-enable bit. A full silo drops new arrivals and raises a sticky overflow output.

Top module: `mrs_rx_silo`

## Requirements
- R1: A popped entry reads as bit 15 = 1 (valid), bits 7:0 = character and bits 10:8 = source line. Bits 14, 13, 12 and 11 read as 0 for a normal character.
- R2: A break on a line is stored as an entry with bits 15 and 13 set, the line number in bits 10:8 and character bits 7:0 equal to zero.
- R3: Characters that arrive on several lines in the same cycle enter the silo lowest line number first.
- R4: A read of word 1 always clears the alarm bit (word 0 bit 13). While the scan enable (word 0 bit 5) is 0, that read returns 0 and removes nothing.
- R5: The done bit (word 0 bit 7) is 1 exactly when scan is enabled and the silo holds at least one entry.
- R6: When armed, the alarm sets bit 13 once the silo holds ALARM_LEVEL (16) or more entries, then disarms. It re-arms only when a scanned read finds the silo empty, or on clear.
- R7: `rx_irq` is 1 when the interrupt enable (bit 6) is 1 and the selected flag is 1. The selected flag is the alarm bit when alarm enable (bit 12) is 1, and the done bit when bit 12 is 0.
- R8: Writing word 1 picks a line with bits 2:0. Bit 12 switches that line's receiver on (1) or off (0). Characters on a line that is off are discarded. All lines are off after reset.
- R9: While scan is 0, the done and alarm bits read as 0.
- R10: The silo holds DEPTH (64) entries. An arrival that finds it full is dropped and sets `silo_ovf`, which stays 1 until reset or clear.
- R11: Read data is registered. It is valid in the cycle after the read strobe, and the entry is removed on that same edge. A scanned read of an empty silo returns 0.
- R12: Writing word 0 with bit 4 = 1 empties the silo, zeroes the control bits, switches off every line, clears `silo_ovf` and re-arms the alarm.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | active-low synchronous reset |
| reg_wr | input | 1 | register write strobe |
| reg_rd | input | 1 | register read strobe |
| reg_addr | input | 1 | 0 = control/status word, 1 = buffer (read) / line parameter (write) |
| reg_wdata | input | 16 | write data |
| reg_rdata | output | 16 | registered read data |
| ln_valid | input | 8 | per-line character strobe |
| ln_data | input | 64 | per-line character, line n at bits 8n+7:8n |
| ln_break | input | 8 | per-line break qualifier for the strobe |
| rx_irq | output | 1 | receive interrupt request |
| silo_ovf | output | 1 | sticky silo overflow |

## Verification
Suppose a line strobe is sampled at edge k. The line's holding slot captures it at k, and the silo entry, fill count, done and alarm flags change at k+1 at the earliest. Later lines in the same burst follow one per cycle. The bench therefore waits ten edges after every burst before it reads status. Register writes and reads take effect on the single edge between two falling edges. The bench drives on one falling edge and samples `reg_rdata`, `rx_irq` and `silo_ovf` on the next. It compares each popped word against a queue model in the bench, and compares the flags against status words computed from that model.

// File: rtl/mrs_pkg.sv
package mrs_pkg;
    // control/status word bit positions
    localparam int CTL_CLR  = 4;
    localparam int CTL_SCAN = 5;
    localparam int CTL_IE   = 6;
    localparam int CTL_DONE = 7;
    localparam int CTL_AE   = 12;
    localparam int CTL_ALM  = 13;
    // buffer word bit positions
    localparam int BUF_LINE = 8;
    localparam int BUF_FRM  = 13;
    localparam int BUF_VLD  = 15;
    // line parameter write
    localparam int LPR_ON   = 12;
    localparam int CHW      = 8;

    typedef struct packed {
        logic           pend;
        logic           brk;
        logic [CHW-1:0] ch;
    } slot_t;
endpackage

// File: rtl/mrs_line_slot.sv
module mrs_line_slot
    import mrs_pkg::*;
(
    input  logic           clk,
    input  logic           rst_n,
    input  logic           en,
    input  logic           in_valid,
    input  logic [CHW-1:0] in_data,
    input  logic           in_brk,
    input  logic           take,
    output logic           pend,
    output logic           brk,
    output logic [CHW-1:0] ch
);
    slot_t slot_d, slot_q;

    always_comb begin
        slot_d = slot_q;
        if (take) slot_d.pend = 1'b0;
        if (!en) begin
            slot_d.pend = 1'b0;
        end else if (in_valid && !slot_d.pend) begin
            slot_d.pend = 1'b1;
            slot_d.brk  = in_brk;
            slot_d.ch   = in_brk ? '0 : in_data;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) slot_q <= '0;
        else        slot_q <= slot_d;
    end

    assign pend = slot_q.pend;
    assign brk  = slot_q.brk;
    assign ch   = slot_q.ch;
endmodule

// File: rtl/mrs_pick.sv
module mrs_pick #(
    parameter int N  = 8,
    localparam int IW = $clog2(N)
) (
    input  logic [N-1:0]  req,
    output logic          any,
    output logic [IW-1:0] idx,
    output logic [N-1:0]  grant
);
    always_comb begin
        any   = |req;
        idx   = '0;
        grant = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) begin
                idx      = IW'(i);
                grant    = '0;
                grant[i] = 1'b1;
            end
        end
    end
endmodule

// File: rtl/mrs_silo_mem.sv
module mrs_silo_mem #(
    parameter int DEPTH = 64,
    parameter int W     = 12,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [W-1:0]  wdata,
    input  logic [AW-1:0] raddr,
    output logic [W-1:0]  rdata
);
    logic [W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    assign rdata = mem[raddr];
endmodule

// File: rtl/mrs_rx_silo.sv
module mrs_rx_silo
    import mrs_pkg::*;
#(
    parameter int LINES       = 8,
    parameter int DEPTH       = 64,
    parameter int ALARM_LEVEL = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 reg_wr,
    input  logic                 reg_rd,
    input  logic                 reg_addr,
    input  logic [15:0]          reg_wdata,
    output logic [15:0]          reg_rdata,
    input  logic [LINES-1:0]     ln_valid,
    input  logic [LINES*CHW-1:0] ln_data,
    input  logic [LINES-1:0]     ln_break,
    output logic                 rx_irq,
    output logic                 silo_ovf
);
    localparam int LW = $clog2(LINES);
    localparam int AW = $clog2(DEPTH);
    localparam int CW = AW + 1;
    localparam int EW = CHW + LW + 1;

    typedef struct packed {
        logic             scan;
        logic             ie;
        logic             ae;
        logic             alarm;
        logic             done;
        logic             armed;
        logic             ovf;
        logic [LINES-1:0] line_en;
        logic [AW-1:0]    wp;
        logic [AW-1:0]    rp;
        logic [CW-1:0]    cnt;
        logic [15:0]      rdata;
    } st_t;

    st_t st_d, st_q;

    logic [LINES-1:0]     pend, brk_v, take;
    logic [CHW-1:0]       ch_v [LINES];
    logic                 pick_any;
    logic [LW-1:0]        pick_idx;
    logic [LINES-1:0]     pick_grant;
    logic                 mem_we;
    logic [EW-1:0]        mem_wdata, head;
    logic                 clr;

    assign clr = reg_wr && !reg_addr && reg_wdata[CTL_CLR];

    for (genvar g = 0; g < LINES; g++) begin : g_line
        mrs_line_slot u_slot (
            .clk      (clk),
            .rst_n    (rst_n),
            .en       (st_q.line_en[g] && !clr),
            .in_valid (ln_valid[g]),
            .in_data  (ln_data[g*CHW +: CHW]),
            .in_brk   (ln_break[g]),
            .take     (take[g]),
            .pend     (pend[g]),
            .brk      (brk_v[g]),
            .ch       (ch_v[g])
        );
    end

    mrs_pick #(.N(LINES)) u_pick (
        .req   (pend & st_q.line_en),
        .any   (pick_any),
        .idx   (pick_idx),
        .grant (pick_grant)
    );

    assign take = pick_grant;

    mrs_silo_mem #(.DEPTH(DEPTH), .W(EW)) u_mem (
        .clk   (clk),
        .we    (mem_we),
        .waddr (st_q.wp),
        .wdata (mem_wdata),
        .raddr (st_q.rp),
        .rdata (head)
    );

    function automatic logic [15:0] fmt_entry(input logic [EW-1:0] e);
        logic [15:0] w;
        w = '0;
        w[BUF_VLD]          = 1'b1;
        w[BUF_FRM]          = e[EW-1];
        w[BUF_LINE +: LW]   = e[CHW +: LW];
        w[CHW-1:0]          = e[CHW-1:0];
        return w;
    endfunction

    function automatic logic [15:0] fmt_status(input st_t s);
        logic [15:0] w;
        w = '0;
        w[CTL_SCAN] = s.scan;
        w[CTL_IE]   = s.ie;
        w[CTL_DONE] = s.done;
        w[CTL_AE]   = s.ae;
        w[CTL_ALM]  = s.alarm;
        return w;
    endfunction

    logic full, empty, do_push, do_pop;

    always_comb begin
        full      = (st_q.cnt == CW'(DEPTH));
        empty     = (st_q.cnt == '0);
        do_push   = pick_any && !full && !clr;
        do_pop    = reg_rd && reg_addr && st_q.scan && !empty && !clr;
        mem_we    = do_push;
        mem_wdata = {brk_v[pick_idx], pick_idx, ch_v[pick_idx]};

        st_d = st_q;
        if (do_push) st_d.wp = st_q.wp + 1'b1;
        if (do_pop)  st_d.rp = st_q.rp + 1'b1;
        st_d.cnt = st_q.cnt + CW'(do_push) - CW'(do_pop);
        if (pick_any && full) st_d.ovf = 1'b1;

        if (reg_rd) begin
            if (reg_addr) begin
                st_d.alarm = 1'b0;
                if (!st_q.scan)  st_d.rdata = '0;
                else if (empty) begin
                    st_d.rdata = '0;
                    st_d.armed = 1'b1;
                end else st_d.rdata = fmt_entry(head);
            end else begin
                st_d.rdata = fmt_status(st_q);
            end
        end

        if (reg_wr) begin
            if (!reg_addr) begin
                st_d.scan = reg_wdata[CTL_SCAN];
                st_d.ie   = reg_wdata[CTL_IE];
                st_d.ae   = reg_wdata[CTL_AE];
            end else begin
                for (int i = 0; i < LINES; i++) begin
                    if (reg_wdata[LW-1:0] == LW'(i))
                        st_d.line_en[i] = reg_wdata[LPR_ON];
                end
            end
        end

        if (!st_d.scan) begin
            st_d.alarm = 1'b0;
        end else if (st_d.armed && st_d.cnt >= CW'(ALARM_LEVEL)) begin
            st_d.alarm = 1'b1;
            st_d.armed = 1'b0;
        end
        st_d.done = st_d.scan && (st_d.cnt != '0);

        if (clr) begin
            st_d       = '0;
            st_d.armed = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q       <= '0;
            st_q.armed <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign reg_rdata = st_q.rdata;
    assign silo_ovf  = st_q.ovf;
    assign rx_irq    = st_q.ie && (st_q.ae ? st_q.alarm : st_q.done);

    // observation points for the bound checker
    logic          scan_on, ie_on, alarm_on, done_on;
    logic [CW-1:0] fill;
    assign scan_on  = st_q.scan;
    assign ie_on    = st_q.ie;
    assign alarm_on = st_q.alarm;
    assign done_on  = st_q.done;
    assign fill     = st_q.cnt;
endmodule

// File: rtl/mrs_rx_silo_chk.sv
module mrs_rx_silo_chk #(
    parameter int DEPTH       = 64,
    parameter int ALARM_LEVEL = 16,
    localparam int CW = $clog2(DEPTH) + 1
) (
    input logic          clk,
    input logic          rst_n,
    input logic          reg_wr,
    input logic          reg_rd,
    input logic          reg_addr,
    input logic [15:0]   reg_wdata,
    input logic          rx_irq,
    input logic          silo_ovf,
    input logic          scan_on,
    input logic          ie_on,
    input logic          alarm_on,
    input logic          done_on,
    input logic [CW-1:0] fill
);
    logic clr_wr;
    assign clr_wr = reg_wr && !reg_addr && reg_wdata[4];

    a_r5_done_needs_scan: assert property (@(posedge clk) disable iff (!rst_n)
        done_on |-> scan_on);

    a_r9_scan_off_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !scan_on |-> (!alarm_on && !done_on));

    a_r6_alarm_level: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(alarm_on) |-> (fill >= CW'(ALARM_LEVEL)));

    a_r4_read_clears_alarm: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd && reg_addr && alarm_on) |=> !alarm_on);

    a_r7_irq_needs_ie: assert property (@(posedge clk) disable iff (!rst_n)
        rx_irq |-> ie_on);

    a_r10_fill_bound: assert property (@(posedge clk) disable iff (!rst_n)
        fill <= CW'(DEPTH));

    a_r10_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (silo_ovf && !clr_wr) |=> silo_ovf);

    a_r12_clear_empties: assert property (@(posedge clk) disable iff (!rst_n)
        clr_wr |=> (fill == '0 && !scan_on && !silo_ovf));
endmodule

bind mrs_rx_silo mrs_rx_silo_chk #(.DEPTH(DEPTH), .ALARM_LEVEL(ALARM_LEVEL)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_wr    (reg_wr),
    .reg_rd    (reg_rd),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .rx_irq    (rx_irq),
    .silo_ovf  (silo_ovf),
    .scan_on   (scan_on),
    .ie_on     (ie_on),
    .alarm_on  (alarm_on),
    .done_on   (done_on),
    .fill      (fill)
);

// File: tb/sim_mrs_rx_silo.sv
module sim_mrs_rx_silo;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0, reg_rd = 1'b0, reg_addr = 1'b0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic [7:0]  ln_valid = '0, ln_break = '0;
    logic [63:0] ln_data = '0;
    logic        rx_irq, silo_ovf;

    int total = 0, bad = 0;
    bit finished = 0;
    logic [15:0] q [$];
    bit [7:0]    en_m = '0;
    bit          ovf_m = 0;

    always #10 clk = ~clk;

    mrs_rx_silo u0 (.*);

    function automatic logic [15:0] ent(int line, logic [7:0] ch, bit brk);
        return brk ? (16'hA000 | 16'(line << 8)) : (16'h8000 | 16'(line << 8) | 16'(ch));
    endfunction

    function automatic logic [15:0] stw(bit scan, bit ie, bit done, bit ae, bit alm);
        return (16'(scan) << 5) | (16'(ie) << 6) | (16'(done) << 7) |
               (16'(ae) << 12) | (16'(alm) << 13);
    endfunction

    function automatic bit exp_irq(bit ie, bit ae, bit alm, bit done);
        return ie && (ae ? alm : done);
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(logic a, logic [15:0] v);
        @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = v;
        @(negedge clk); reg_wr = 1'b0;
        if (a && v[2:0] < 8) en_m[v[2:0]] = v[12];
        if (!a && v[4]) begin q.delete(); en_m = '0; ovf_m = 0; end
    endtask

    task automatic rd(logic a, output logic [15:0] v);
        @(negedge clk); reg_rd = 1'b1; reg_addr = a;
        @(negedge clk); reg_rd = 1'b0; v = reg_rdata;
    endtask

    task automatic arrive(logic [7:0] mask, logic [7:0] ch, bit brk);
        @(negedge clk);
        ln_valid = mask; ln_break = brk ? mask : '0;
        for (int l = 0; l < 8; l++) ln_data[l*8 +: 8] = ch + 8'(l);
        @(negedge clk);
        ln_valid = '0; ln_break = '0;
        for (int l = 0; l < 8; l++) begin
            if (mask[l] && en_m[l]) begin
                if (q.size() < 64) q.push_back(ent(l, ch + 8'(l), brk));
                else ovf_m = 1;
            end
        end
        repeat (10) @(negedge clk);
    endtask

    task automatic drain(string req);
        logic [15:0] v;
        while (q.size() > 0) begin
            rd(1'b1, v);
            chk(req, v, q.pop_front());
        end
        rd(1'b1, v);
        chk("R11 empty read", v, 16'h0000);
    endtask

    initial begin
        logic [15:0] v;
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // reset state
        rd(1'b0, v);  chk("R5 reset status", v, 16'h0000);
        chk("R7 reset irq", rx_irq, 0);
        chk("R10 reset ovf", silo_ovf, 0);
        rd(1'b1, v);  chk("R4 scan off read", v, 16'h0000);

        // lines off after reset: arrival discarded
        arrive(8'h01, 8'h11, 0);
        wr(1'b0, 16'h0060);
        rd(1'b0, v);  chk("R8 reset lines off", v, stw(1,1,0,0,0));
        for (int l = 0; l < 8; l++) wr(1'b1, 16'h1000 | 16'(l));

        // single character, done and irq via done
        arrive(8'h08, 8'h3E, 0);
        rd(1'b0, v);  chk("R5 done set", v, stw(1,1,1,0,0));
        chk("R7 irq on done", rx_irq, exp_irq(1,0,0,1));
        drain("R1");
        rd(1'b0, v);  chk("R5 done clear", v, stw(1,1,0,0,0));
        chk("R7 irq off", rx_irq, 0);

        // simultaneous lines: lowest first
        arrive(8'hA4, 8'h30, 0);
        drain("R3");

        // break
        arrive(8'h40, 8'h55, 1);
        drain("R2");

        // disabled line discards
        wr(1'b1, 16'h0004);
        arrive(8'h10, 8'h20, 0);
        rd(1'b0, v);  chk("R8 disabled line", v, stw(1,1,0,0,0));
        wr(1'b1, 16'h1004);

        // alarm
        wr(1'b0, 16'h1060);
        for (int i = 0; i < 15; i++) arrive(8'(1 << (i % 8)), 8'(i), 0);
        rd(1'b0, v);  chk("R6 below level", v, stw(1,1,1,1,0));
        chk("R7 irq alarm sel off", rx_irq, 0);
        arrive(8'h02, 8'h70, 0);
        rd(1'b0, v);  chk("R6 alarm set", v, stw(1,1,1,1,1));
        chk("R7 irq alarm", rx_irq, 1);
        rd(1'b1, v);  chk("R11 pop", v, q.pop_front());
        rd(1'b0, v);  chk("R4 read clears alarm", v, stw(1,1,1,1,0));
        arrive(8'h04, 8'h71, 0);
        rd(1'b0, v);  chk("R6 disarmed", v, stw(1,1,1,1,0));
        drain("R6");
        for (int i = 0; i < 16; i++) arrive(8'(1 << (i % 8)), 8'(i + 8'h40), 0);
        rd(1'b0, v);  chk("R6 rearmed", v, stw(1,1,1,1,1));

        // scan off
        wr(1'b0, 16'h1040);
        rd(1'b0, v);  chk("R9 scan off flags", v, stw(0,1,0,1,0));
        chk("R7 irq scan off", rx_irq, 0);
        rd(1'b1, v);  chk("R4 scan off no pop", v, 16'h0000);
        wr(1'b0, 16'h0060);
        drain("R4");

        // overflow
        for (int i = 0; i < 66; i++) arrive(8'(1 << (i % 8)), 8'(i), 0);
        chk("R10 ovf set", silo_ovf, ovf_m);
        drain("R10");
        chk("R10 ovf sticky", silo_ovf, 1);

        // constrained random
        for (int it = 0; it < 60; it++) begin
            int r = int'($urandom_range(0, 9));
            if (r == 0) begin
                int l = int'($urandom_range(0, 7));
                wr(1'b1, (16'($urandom_range(0, 1)) << 12) | 16'(l));
            end
            arrive(8'($urandom_range(0, 255)), 8'($urandom_range(0, 255)),
                   $urandom_range(0, 7) == 0);
            rd(1'b0, v);
            chk("R5 random done", v[7], q.size() > 0);
            if (q.size() > 40 || it % 7 == 6) drain("R1 random");
        end
        drain("R1 random");

        // clear
        for (int l = 0; l < 8; l++) wr(1'b1, 16'h1000 | 16'(l));
        arrive(8'h07, 8'h61, 0);
        wr(1'b0, 16'h0010);
        rd(1'b0, v);  chk("R12 clear status", v, 16'h0000);
        chk("R12 clear ovf", silo_ovf, 0);
        wr(1'b0, 16'h0060);
        rd(1'b1, v);  chk("R12 silo flushed", v, 16'h0000);
        arrive(8'h02, 8'h10, 0);
        rd(1'b1, v);  chk("R12 lines off", v, 16'h0000);

        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(20 * 150000);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule